// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block produces the two threshold flags of a dual-clock FIFO. Both are active low. The write side counts accepted writes and the read side counts accepted reads. Each pointer is kept in binary, with one extra wrap bit, and also as a registered Gray copy. The Gray copy crosses into the other clock domain through one capture register.

Each domain turns the captured Gray value back into binary. It subtracts that value from its own pointer to get a fill level from 0 to the full depth. It then compares the fill level with an offset and registers the result as the flag.

- The almost-empty flag lives in the read domain. Its threshold is offset X.
- The almost-full flag lives in the write domain. Its threshold is offset Y.
- Each offset is loaded while its domain's reset is held. The value is either a preset parameter or a value on an input, chosen by a select pin.
- The offsets hold their values after reset is released.
- Each of X and Y must be less than half the depth.

The FIFO's control logic drives the two increment strobes and must never request a write when the FIFO is full or a read when it is empty. A word already moved to an output register counts as read.

Top module: `prog_level_flags`

## Requirements
- R1: While reset is held and right after release with no traffic, `ae_n` is 0 and `af_n` is 1.
- R2: Once both domains have settled, `ae_n` is 0 when the fill level is X or less and 1 when it is X+1 or more.
- R3: Once settled, `af_n` is 0 when the fill level is DEPTH-Y or more and 1 when it is DEPTH-(Y+1) or less.
- R4: The write strobe is sampled at a write-clock edge that raises the fill to X+1. `ae_n` stays 0 after the first following read-clock edge and becomes 1 at the second.
- R5: The read strobe is sampled at a read-clock edge that lowers the fill to DEPTH-(Y+1). `af_n` stays 0 after the first following write-clock edge and becomes 1 at the second.
- R6: A local event acts at the clock edge that samples it, with no synchronisation delay. A read that lowers the fill from X+1 to X drives `ae_n` to 0 at that read-clock edge. A write that raises the fill from DEPTH-Y-1 to DEPTH-Y drives `af_n` to 0 at that write-clock edge.
- R7: During reset, `use_preset`=1 loads X=X_DEF and Y=Y_DEF. `use_preset`=0 loads X from `x_in` and Y from `y_in`.
- R8: Changes on `x_in`, `y_in` or `use_preset` after reset release have no effect on either threshold.
- R9: The fill level covers the whole range from 0 to DEPTH and stays correct across pointer wrap. At DEPTH words, `af_n` is 0 and `ae_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low (loads Y) |
| wr_inc | input | 1 | Accepted write; advances the write pointer |
| y_in | input | AW | Parallel value for Y, used when `use_preset`=0 |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low (loads X) |
| rd_inc | input | 1 | Accepted read; advances the read pointer |
| x_in | input | AW | Parallel value for X, used when `use_preset`=0 |
| use_preset | input | 1 | 1 selects the preset offsets at reset, 0 selects `x_in`/`y_in` |
| ae_n | output | 1 | Almost-empty flag, read domain, active low |
| af_n | output | 1 | Almost-full flag, write domain, active low |

## Verification
The bench builds the block with AW=4 (a depth of 16), X_DEF=3 and Y_DEF=2. A full FIFO and many pointer wraps are then only a few dozen operations away. Both thresholds sit close to the empty and full ends, so the random phase crosses each of them often.

The two clocks have periods of 5 ns and 7.2 ns, and their rising edges never coincide. This makes the count of remote edges in the latency checks exact. A second reset with `use_preset`=0 loads X=5 and Y=4 from the inputs. The inputs are then changed to show that nothing reloads the offsets outside reset.

// File: rtl/prog_level_flags.sv
`timescale 1ns/100ps
module prog_level_flags #(
  parameter int AW    = 6,
  parameter int X_DEF = 8,
  parameter int Y_DEF = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_inc,
  input  logic [AW-1:0] y_in,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_inc,
  input  logic [AW-1:0] x_in,
  input  logic          use_preset,
  output logic          ae_n,
  output logic          af_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW+1:0] LIM = (AW+2)'(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin, wgray, rg_s, wbin_nx, fill_w;
  logic [AW:0] rbin, rgray, wg_s, rbin_nx, fill_r;
  logic [AW-1:0] x_q, y_q;
  logic [AW+1:0] af_sum;

  assign wbin_nx = wbin + {{AW{1'b0}}, wr_inc};
  assign fill_w  = wbin_nx - g2b(rg_s);
  assign af_sum  = {1'b0, fill_w} + {2'b00, y_q};

  always_ff @(posedge wclk)
    if (!wrst_n) y_q <= use_preset ? AW'(Y_DEF) : y_in;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s  <= '0;
      af_n  <= 1'b1;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      rg_s  <= rgray;
      af_n  <= af_sum < LIM;
    end

  assign rbin_nx = rbin + {{AW{1'b0}}, rd_inc};
  assign fill_r  = g2b(wg_s) - rbin_nx;

  always_ff @(posedge rclk)
    if (!rrst_n) x_q <= use_preset ? AW'(X_DEF) : x_in;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s  <= '0;
      ae_n  <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      wg_s  <= wgray;
      ae_n  <= fill_r > {1'b0, x_q};
    end
endmodule

module prog_level_flags_chk #(
  parameter int AW = 6
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          wr_inc,
  input logic          rclk,
  input logic          rrst_n,
  input logic          rd_inc,
  input logic          ae_n,
  input logic          af_n,
  input logic [AW-1:0] x_q,
  input logic [AW-1:0] y_q
);
  // R6
  ae_fall_local_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $fell(ae_n) |-> $past(rd_inc));
  // R6
  af_fall_local_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $fell(af_n) |-> $past(wr_inc));
  // R8
  x_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n) $stable(x_q));
  // R8
  y_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n) $stable(y_q));
endmodule

bind prog_level_flags prog_level_flags_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wr_inc(wr_inc),
  .rclk(rclk), .rrst_n(rrst_n), .rd_inc(rd_inc),
  .ae_n(ae_n), .af_n(af_n), .x_q(x_q), .y_q(y_q)
);

// File: tb/test_prog_level_flags.sv
`timescale 1ns/100ps
module test_prog_level_flags;
  localparam int AW = 4;
  localparam int DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0, wr_inc = 0, rd_inc = 0, use_preset = 1;
  logic [AW-1:0] x_in = 0, y_in = 0;
  logic ae_n, af_n;
  int checks = 0, errors = 0, cnt = 0, ex_x = 3, ex_y = 2;

  prog_level_flags #(.AW(AW), .X_DEF(3), .Y_DEF(2)) i_prog_level_flags (
    .wclk(wclk), .wrst_n(wrst_n), .wr_inc(wr_inc), .y_in(y_in),
    .rclk(rclk), .rrst_n(rrst_n), .rd_inc(rd_inc), .x_in(x_in),
    .use_preset(use_preset), .ae_n(ae_n), .af_n(af_n));

  always #2.5 wclk = ~wclk;
  always #3.6 rclk = ~rclk;

  function automatic logic exp_ae(int f);
    return f > ex_x;
  endfunction
  function automatic logic exp_af(int f);
    return !(f >= DEPTH - ex_y);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b fill=%0d", tag, act, exp, cnt);
    end
  endtask

  task automatic wr1();
    @(negedge wclk) wr_inc = 1;
    @(posedge wclk);
    fork begin #1 wr_inc = 0; end join_none
    cnt++;
  endtask

  task automatic rd1();
    @(negedge rclk) rd_inc = 1;
    @(posedge rclk);
    fork begin #1 rd_inc = 0; end join_none
    cnt--;
  endtask

  task automatic settle();
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #1;
  endtask

  task automatic do_reset();
    wrst_n = 0; rrst_n = 0;
    repeat (4) @(posedge rclk);
    repeat (2) @(posedge wclk);
    #1;
    chk("R1 ae_n in reset", ae_n, 1'b0);
    chk("R1 af_n in reset", af_n, 1'b1);
    @(negedge wclk) wrst_n = 1;
    @(negedge rclk) rrst_n = 1;
    cnt = 0;
  endtask

  task automatic both(input string tag);
    settle();
    chk({tag, " ae_n"}, ae_n, exp_ae(cnt));
    chk({tag, " af_n"}, af_n, exp_af(cnt));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    use_preset = 1; ex_x = 3; ex_y = 2;
    do_reset();
    settle();
    chk("R1 ae_n after release", ae_n, 1'b0);
    chk("R1 af_n after release", af_n, 1'b1);

    repeat (3) wr1();
    both("R2 fill=X R7 preset");
    wr1();
    @(posedge rclk); #1;
    chk("R4 ae_n after first read edge", ae_n, 1'b0);
    @(posedge rclk); #1;
    chk("R4 ae_n after second read edge", ae_n, 1'b1);
    settle();
    rd1(); #1;
    chk("R6 local read lowers ae_n", ae_n, 1'b0);
    wr1();
    both("R2 fill=X+1");

    while (cnt < DEPTH - ex_y - 1) wr1();
    both("R3 fill=DEPTH-Y-1");
    wr1(); #1;
    chk("R6 local write lowers af_n", af_n, 1'b0);
    settle();
    rd1();
    @(posedge wclk); #1;
    chk("R5 af_n after first write edge", af_n, 1'b0);
    @(posedge wclk); #1;
    chk("R5 af_n after second write edge", af_n, 1'b1);

    while (cnt < DEPTH) wr1();
    both("R9 full");
    while (cnt > 0) rd1();
    both("R9 drained");

    for (int i = 0; i < 250; i++) begin
      if (($urandom % 2 == 0 && cnt < DEPTH) || cnt == 0) wr1();
      else rd1();
      both("R2 R3 R9 random");
    end
    while (cnt > 0) rd1();

    use_preset = 0; x_in = 5; y_in = 4;
    do_reset();
    ex_x = 5; ex_y = 4;
    x_in = 1; y_in = 1; use_preset = 1;
    repeat (5) wr1();
    both("R7 R8 fill=X loaded");
    wr1();
    both("R7 R8 fill=X+1 loaded");
    while (cnt < DEPTH - ex_y - 1) wr1();
    both("R8 fill=DEPTH-Y-1 loaded");
    wr1();
    both("R7 R8 fill=DEPTH-Y loaded");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule